// File: doc/BRIEF.md
# Infrared Carrier Modulator Timer

This block drives an infrared-style output pin. It makes a square carrier from a high time and a low time that are programmed separately, and gates that carrier with a modulation envelope. The envelope repeats as a mark phase followed by a space phase. A power-of-two divider on the input clock produces a tick, and every duration is counted in ticks.

There are four operating modes. Plain carrier mode gates one carrier pair. Baseband mode puts the envelope itself on the pin. Two-frequency mode switches between a primary and an alternate carrier pair on each new modulation cycle. Direct mode lets software drive the pin level. Any of the three generated modes can add extended space, which blanks the mark so that the whole cycle is space. Each cycle ends with a one-clock end-of-cycle pulse. With the output gate off, that pulse still runs, so the block can serve as a plain periodic timer.

Configuration is captured when a modulation cycle starts. Software can therefore prepare the next cycle while the current one is still being sent.

Top module: `ir_carrier_mod`

## Requirements
- R1: While reset is high and on the first clock after it, `pin_out` is 0 unless direct mode with `out_en`=1 and `sw_level`=1 is selected, and `eoc_irq` is 0.
- R2: The divider emits one tick every 2^`div_sel` clocks. The counting restarts at each start from idle, so all mark, space and carrier durations scale by 2^`div_sel` clocks.
- R3: In plain carrier mode (`mode_sel`=0), the pin is high during mark for `hi_pri`+1 ticks, then low for `lo_pri`+1 ticks, and this repeats. The carrier restarts high at every cycle start.
- R4: Mark lasts `mark_len`+1 ticks and space lasts `space_len`+1 ticks. The pin is low throughout space.
- R5: In baseband mode (`mode_sel`=1), the pin is high for the whole mark and low for the whole space.
- R6: In two-frequency mode (`mode_sel`=2), the first cycle after a start from idle uses `hi_pri`/`lo_pri`. Each following cycle uses the other pair in turn (`hi_alt`/`lo_alt`, then the primary pair, and so on).
- R7: With `ext_space`=1, the pin stays low for the whole cycle. Cycle length and `eoc_irq` are unchanged.
- R8: `eoc_irq` is a one-clock pulse on the first clock of each new cycle, following the final space tick.
- R9: With `out_en`=0, the pin is low in every mode. Cycle timing and `eoc_irq` continue unchanged.
- R10: In direct mode (`mode_sel`=3), `pin_out` equals `out_en` AND `sw_level` in the same cycle. The generator stops and gives no `eoc_irq`. Leaving direct mode starts a new cycle with the primary pair.
- R11: Changes to lengths, carrier times, `ext_space`, or the mode among 0, 1 and 2 take effect only at the next cycle start.
- R12: Dropping `en` stops the generator and forces the pin low from the next clock. Raising `en` again begins a new cycle at mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Generator enable |
| mode_sel | input | 2 | 0 plain carrier, 1 baseband, 2 two-frequency, 3 direct |
| div_sel | input | DIV_W | Tick divider exponent (divide by 2^div_sel) |
| hi_pri | input | CAR_W | Primary carrier high time minus one, in ticks |
| lo_pri | input | CAR_W | Primary carrier low time minus one, in ticks |
| hi_alt | input | CAR_W | Alternate carrier high time minus one |
| lo_alt | input | CAR_W | Alternate carrier low time minus one |
| mark_len | input | ENV_W | Mark length minus one, in ticks |
| space_len | input | ENV_W | Space length minus one, in ticks |
| ext_space | input | 1 | Treat mark as space for the cycle |
| out_en | input | 1 | Output gate; 0 leaves timer-only operation |
| sw_level | input | 1 | Pin level in direct mode |
| pin_out | output | 1 | Modulated output |
| eoc_irq | output | 1 | End-of-cycle pulse |

## Verification
Some properties hold on every cycle, and the assertions check those:
- the end-of-cycle pulse never lasts two clocks;
- direct mode suppresses that pulse;
- every cycle start puts both the envelope and the carrier high;
- the captured configuration and the carrier and envelope levels only move on a cycle start or a tick.

The bench's scenarios are needed for the rest: exact durations under each divider setting, the primary and alternate alternation, the deferral of mid-cycle changes, and restart after disable or after direct mode. A clock-by-clock reference model checks those scenarios against the pin and the pulse.

// File: rtl/ircm_pkg.sv
package ircm_pkg;

    typedef enum logic [1:0] {
        MODE_TIME   = 2'd0,
        MODE_BASE   = 2'd1,
        MODE_FSK    = 2'd2,
        MODE_DIRECT = 2'd3
    } ircm_mode_e;

    // Last divider count before a tick: 2^sel - 1
    function automatic int div_limit(input int sel);
        return (1 << sel) - 1;
    endfunction

endpackage

// File: rtl/ircm_prescale.sv
module ircm_prescale #(
    parameter int DIV_W = 2,
    localparam int PRE_W = (1 << DIV_W) - 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div_sel,
    output logic             tick
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] lim;

    assign lim  = PRE_W'(ircm_pkg::div_limit(int'(div_sel)));
    assign tick = run && (pre_q == lim);

    always_ff @(posedge clk) begin
        if (rst || !run)       pre_q <= '0;
        else if (pre_q == lim) pre_q <= '0;
        else                   pre_q <= pre_q + 1'b1;
    end
endmodule

// File: rtl/ircm_carrier.sv
module ircm_carrier #(
    parameter int CAR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CAR_W-1:0] hi_ld,
    input  logic             tick,
    input  logic [CAR_W-1:0] hi_cur,
    input  logic [CAR_W-1:0] lo_cur,
    output logic             lvl
);
    logic [CAR_W-1:0] cnt_q;
    logic             lvl_q;

    assign lvl = lvl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= 1'b0;
            cnt_q <= '0;
        end else if (load) begin
            lvl_q <= 1'b1;
            cnt_q <= hi_ld;
        end else if (tick) begin
            if (cnt_q == '0) begin
                lvl_q <= !lvl_q;
                cnt_q <= lvl_q ? lo_cur : hi_cur;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // R3: carrier level moves only on a tick or a cycle start
    assert_carrier_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
        (!load && !tick) |=> $stable(lvl_q));
endmodule

// File: rtl/ircm_envelope.sv
module ircm_envelope #(
    parameter int ENV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [ENV_W-1:0] mark_ld,
    input  logic [ENV_W-1:0] space_cur,
    input  logic             tick,
    output logic             in_mark,
    output logic             cyc_end
);
    logic [ENV_W-1:0] cnt_q;
    logic             mark_q;

    assign in_mark = mark_q;
    assign cyc_end = tick && !mark_q && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            mark_q <= 1'b0;
            cnt_q  <= '0;
        end else if (load) begin
            mark_q <= 1'b1;
            cnt_q  <= mark_ld;
        end else if (tick) begin
            if (cnt_q == '0) begin
                if (mark_q) begin
                    mark_q <= 1'b0;
                    cnt_q  <= space_cur;
                end
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // R4: envelope phase moves only on a tick or a cycle start
    assert_phase_on_tick_R4: assert property (@(posedge clk) disable iff (rst)
        (!load && !tick) |=> $stable(mark_q));
endmodule

// File: rtl/ir_carrier_mod.sv
module ir_carrier_mod #(
    parameter int CAR_W = 8,
    parameter int ENV_W = 16,
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [1:0]       mode_sel,
    input  logic [DIV_W-1:0] div_sel,
    input  logic [CAR_W-1:0] hi_pri,
    input  logic [CAR_W-1:0] lo_pri,
    input  logic [CAR_W-1:0] hi_alt,
    input  logic [CAR_W-1:0] lo_alt,
    input  logic [ENV_W-1:0] mark_len,
    input  logic [ENV_W-1:0] space_len,
    input  logic             ext_space,
    input  logic             out_en,
    input  logic             sw_level,
    output logic             pin_out,
    output logic             eoc_irq
);
    import ircm_pkg::*;

    typedef struct packed {
        ircm_mode_e       mode;
        logic             xsp;
        logic [ENV_W-1:0] space;
        logic [CAR_W-1:0] hi;
        logic [CAR_W-1:0] lo;
    } cyc_cfg_t;

    ircm_mode_e mode_in;
    cyc_cfg_t   cfg_q, cfg_nxt;
    logic       run_q, fsk_q, eoc_q;
    logic       tick, in_mark, cyc_end, car_lvl;
    logic       start_idle, stop, load, fsk_nxt, use_alt;

    assign mode_in    = ircm_mode_e'(mode_sel);
    assign start_idle = !run_q && en && (mode_in != MODE_DIRECT);
    assign stop       = run_q && (!en || (mode_in == MODE_DIRECT));
    assign load       = start_idle || (run_q && !stop && cyc_end);
    assign fsk_nxt    = start_idle ? 1'b0 : !fsk_q;
    assign use_alt    = (mode_in == MODE_FSK) && fsk_nxt;

    always_comb begin
        cfg_nxt.mode  = mode_in;
        cfg_nxt.xsp   = ext_space;
        cfg_nxt.space = space_len;
        cfg_nxt.hi    = use_alt ? hi_alt : hi_pri;
        cfg_nxt.lo    = use_alt ? lo_alt : lo_pri;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            fsk_q <= 1'b0;
            eoc_q <= 1'b0;
            cfg_q <= '0;
        end else begin
            run_q <= start_idle || (run_q && !stop);
            eoc_q <= run_q && !stop && cyc_end;
            if (load) begin
                cfg_q <= cfg_nxt;
                fsk_q <= fsk_nxt;
            end
        end
    end

    ircm_prescale #(.DIV_W(DIV_W)) u_pre (
        .clk(clk), .rst(rst), .run(run_q), .div_sel(div_sel), .tick(tick)
    );

    ircm_envelope #(.ENV_W(ENV_W)) u_env (
        .clk(clk), .rst(rst), .load(load), .mark_ld(mark_len),
        .space_cur(cfg_q.space), .tick(tick), .in_mark(in_mark), .cyc_end(cyc_end)
    );

    ircm_carrier #(.CAR_W(CAR_W)) u_car (
        .clk(clk), .rst(rst), .load(load), .hi_ld(cfg_nxt.hi), .tick(tick),
        .hi_cur(cfg_q.hi), .lo_cur(cfg_q.lo), .lvl(car_lvl)
    );

    always_comb begin
        if (mode_in == MODE_DIRECT)
            pin_out = out_en && sw_level;
        else
            pin_out = out_en && run_q && in_mark && !cfg_q.xsp &&
                      ((cfg_q.mode == MODE_BASE) || car_lvl);
    end

    assign eoc_irq = eoc_q;

    // R8: end-of-cycle is a single-clock pulse
    assert_eoc_single_R8: assert property (@(posedge clk) disable iff (rst)
        eoc_irq |=> !eoc_irq);
    // R10: direct mode never reports an end of cycle
    assert_direct_no_eoc_R10: assert property (@(posedge clk) disable iff (rst)
        (mode_in == MODE_DIRECT) |=> !eoc_irq);
    // R3 / R4: each cycle opens in mark with the carrier high
    assert_cycle_opens_high_R3: assert property (@(posedge clk) disable iff (rst)
        load |=> (in_mark && car_lvl));
    // R11: captured configuration holds for the whole cycle
    assert_cfg_held_R11: assert property (@(posedge clk) disable iff (rst)
        (run_q && !load) |=> $stable(cfg_q));
endmodule

// File: tb/ir_carrier_mod_bench.sv
module ir_carrier_mod_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic [1:0] mode_sel = 2'd0;
    logic [1:0] div_sel = 2'd0;
    logic [7:0] hi_pri = 8'd2, lo_pri = 8'd1, hi_alt = 8'd0, lo_alt = 8'd0;
    logic [15:0] mark_len = 16'd9, space_len = 16'd4;
    logic       ext_space = 1'b0, out_en = 1'b1, sw_level = 1'b0;
    logic       pin_out, eoc_irq;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    // reference model state
    bit m_run = 0, m_eoc = 0, m_fs = 0, m_xsp = 0;
    int m_t = 0, m_M = 0, m_S = 0, m_H = 1, m_L = 1, m_mode = 0;

    always #5 clk = !clk;

    ir_carrier_mod u_ir_carrier_mod (
        .clk(clk), .rst(rst), .en(en), .mode_sel(mode_sel), .div_sel(div_sel),
        .hi_pri(hi_pri), .lo_pri(lo_pri), .hi_alt(hi_alt), .lo_alt(lo_alt),
        .mark_len(mark_len), .space_len(space_len), .ext_space(ext_space),
        .out_en(out_en), .sw_level(sw_level), .pin_out(pin_out), .eoc_irq(eoc_irq)
    );

    task automatic m_start();
        int d;
        bit alt;
        d = 1 << div_sel;
        alt = (mode_sel == 2'd2) && m_fs;
        m_run = 1; m_t = 0;
        m_M = (int'(mark_len) + 1) * d;
        m_S = (int'(space_len) + 1) * d;
        m_H = (int'(alt ? hi_alt : hi_pri) + 1) * d;
        m_L = (int'(alt ? lo_alt : lo_pri) + 1) * d;
        m_xsp = ext_space;
        m_mode = int'(mode_sel);
    endtask

    always @(posedge clk) begin
        m_eoc = 0;
        if (rst) begin
            m_run = 0; m_fs = 0; m_t = 0;
        end else if (!m_run) begin
            if (en && mode_sel != 2'd3) begin m_fs = 0; m_start(); end
        end else if (!en || mode_sel == 2'd3) begin
            m_run = 0;
        end else begin
            m_t++;
            if (m_t == m_M + m_S) begin m_eoc = 1; m_fs = !m_fs; m_start(); end
        end
    end

    function automatic bit exp_pin();
        if (mode_sel == 2'd3) return out_en && sw_level;
        if (!out_en || !m_run || m_t >= m_M || m_xsp) return 0;
        if (m_mode == 1) return 1;
        return (m_t % (m_H + m_L)) < m_H;
    endfunction

    always @(negedge clk) begin
        if (!done) begin
            n_cmp++;
            if (pin_out !== exp_pin() || eoc_irq !== m_eoc) begin
                n_bad++;
                $display("FAIL %s t=%0t pin=%b exp=%b eoc=%b exp=%b",
                         cur_req, $time, pin_out, exp_pin(), eoc_irq, m_eoc);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic run(int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    initial begin
        cur_req = "R1";                    // reset state, compared each clock
        run(4); rst = 1'b0; run(2);
        cur_req = "R3"; en = 1'b1; run(70);
        cur_req = "R2"; en = 1'b0; run(2); div_sel = 2'd2; en = 1'b1; run(160);
        en = 1'b0; run(2); div_sel = 2'd3; hi_pri = 8'd0; lo_pri = 8'd2; en = 1'b1; run(220);
        cur_req = "R4"; en = 1'b0; run(2); div_sel = 2'd0; mark_len = 16'd0; space_len = 16'd0;
        hi_pri = 8'd0; lo_pri = 8'd0; en = 1'b1; run(20);
        cur_req = "R5"; mark_len = 16'd6; space_len = 16'd3; mode_sel = 2'd1; run(60);
        cur_req = "R6"; en = 1'b0; run(2); mode_sel = 2'd2; hi_pri = 8'd3; lo_pri = 8'd2;
        hi_alt = 8'd0; lo_alt = 8'd0; mark_len = 16'd11; en = 1'b1; run(120);
        cur_req = "R7"; ext_space = 1'b1; run(50);
        cur_req = "R11"; run(3); ext_space = 1'b0; mode_sel = 2'd0; mark_len = 16'd4;
        hi_pri = 8'd1; run(5); mode_sel = 2'd1; space_len = 16'd7; run(60);
        cur_req = "R9"; out_en = 1'b0; run(45); out_en = 1'b1; run(10);
        cur_req = "R10"; mode_sel = 2'd3; run(3); sw_level = 1'b1; run(3);
        out_en = 1'b0; run(2); out_en = 1'b1; run(2); sw_level = 1'b0; run(3);
        sw_level = 1'b1; run(2); mode_sel = 2'd2; run(80);
        cur_req = "R12"; run(7); en = 1'b0; run(6); mode_sel = 2'd0; en = 1'b1; run(50);
        cur_req = "R1"; rst = 1'b1; run(3); rst = 1'b0; run(5);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule